// File: doc/BRIEF.md
# Configurable Serial Transceiver

An asynchronous serial transmitter and receiver pair behind a small synchronous register bus. Software picks the character width (5 to 9 data bits), the parity mode and one or two stop bits. It then writes characters into a one-deep transmit buffer that feeds a shift register. The receiver oversamples its input line and returns each character with parity and framing status. In 9-bit mode the extra data bit is moved through a control-register bit. Its value is staged by the order in which software accesses the registers.

Register map (3-bit address):

- 0 is the data port. A write commits a character and a read pops the received one.
- 1 is control: bit0 transmit enable, bit1 receive enable, bit2 high size bit, bit3 transmit ninth bit, bit4 received ninth bit (read-only).
- 2 is the frame format: bits[1:0] low size field, bits[3:2] parity mode, bit4 two stop bits.
- 3 is status (read-only): bit0 transmit buffer empty, bit1 transmitter idle, bit2 character held, bit3 parity error, bit4 framing error, bit5 line driven.
- 4 is the baud divisor.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the frame-format register reads 0x03 (8 bits, parity off, one stop), control reads 0x00, status reads 0x03, `txd` is high and `tx_drive` is low.
- R2: The size code is {control bit2, format bits[1:0]}. Codes 000, 001, 010 and 011 give 5 to 8 data bits, 111 gives 9, and the other codes give 8. Received bits above the size read as 0.
- R3: A frame is a low start bit, then the data bits LSB first, then the ninth bit when present, then the parity bit when enabled, then one high stop bit, or two when format bit4 is 1. The idle line is high.
- R4: Parity mode (format bits[3:2]): 00 off, 01 behaves as off, 10 even, 11 odd. The transmitter appends the parity bit computed over all data bits.
- R5: The receiver sets status bit3 when the received parity bit disagrees with the selected mode. It sets status bit4 when the first stop bit samples low. Both flags belong to the held character.
- R6: Writing the data port commits {control bit3, written byte} as one 9-bit character. A later change to control bit3 does not alter a committed character.
- R7: The received ninth bit reads in control bit4 while a character is held. Reading the data port pops the character: status bits 2 to 4 and control bit4 then read 0.
- R8: When transmit enable is cleared, buffered and shifting characters are still sent and `tx_drive` stays high. Once both stages are empty, `tx_drive` goes low with `txd` high. Data written while disabled is held until the transmitter is enabled again.
- R9: Each bit lasts 16 ticks of the baud divider. The receiver decides each bit by a majority of the samples at ticks 7, 8 and 9. A one-sample disturbance at the centre is ignored, and a start pulse that is high at the centre is rejected.
- R10: A baud tick occurs every divisor+1 clocks, so one bit time lasts 16×(divisor+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops data on address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_drive | output | 1 | High while the transmitter owns the line |

## Verification
The assertions assume that the format register and the size bits are not changed while a frame is on the line or a character is held unread. The parity flag is only meaningful against the mode that was in force when the character arrived. The stimulus changes the configuration only after the transmitter reports idle and the last character has been popped. Frames are driven onto the receive line directly only while the transmitter is silent. Every received character is read before the next one completes.

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_drive
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] S_LO  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S_MID = CW'(OVS/2);
  localparam logic [CW-1:0] S_END = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] S_TOP = CW'(OVS - 1);

  logic tx_en, rx_en, size_hi, tx_b8, stop2;
  logic [1:0] size_lo, par_mode;
  logic [DIV_W-1:0] div, div_cnt;
  logic tick;

  logic [3:0] nbits;
  logic [8:0] dmask;
  logic par_on, par_odd;

  always_comb
    case ({size_hi, size_lo})
      3'd0: nbits = 4'd5;
      3'd1: nbits = 4'd6;
      3'd2: nbits = 4'd7;
      3'd7: nbits = 4'd9;
      default: nbits = 4'd8;
    endcase

  assign dmask   = 9'h1FF >> (4'd9 - nbits);
  assign par_on  = par_mode[1];
  assign par_odd = par_mode[0];
  assign tick    = (div_cnt == div);

  wire wr_data = bus_wr && bus_addr == 3'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0; size_hi <= 1'b0; tx_b8 <= 1'b0;
      size_lo <= 2'b11; par_mode <= 2'b00; stop2 <= 1'b0;
      div <= '0; div_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (bus_wr)
        case (bus_addr)
          3'd1: {tx_b8, size_hi, rx_en, tx_en} <= bus_wdata[3:0];
          3'd2: {stop2, par_mode, size_lo} <= bus_wdata[4:0];
          3'd4: div <= DIV_W'(bus_wdata);
          default: ;
        endcase
    end

  // transmitter
  logic [8:0]  tx_buf;
  logic        tx_buf_full, tx_busy, tx_act;
  logic [12:0] tx_sh, tx_frame;
  logic [3:0]  tx_left, tx_len;
  logic [CW-1:0] tx_sub;
  logic [8:0]  tx_d;
  logic        tx_p, load;

  assign tx_d   = tx_buf & dmask;
  assign tx_p   = ^tx_d ^ par_odd;
  assign tx_len = 4'd2 + nbits + {3'd0, par_on} + {3'd0, stop2};
  assign load   = tx_act && tx_buf_full && !tx_busy && tick;

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nbits)) tx_frame[i+1] = tx_d[i];
    if (par_on) tx_frame[nbits + 4'd1] = tx_p;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_buf <= '0; tx_buf_full <= 1'b0; tx_busy <= 1'b0; tx_act <= 1'b0;
      tx_sh <= '1; tx_left <= '0; tx_sub <= '0;
    end else begin
      tx_act <= tx_en || (tx_act && (tx_buf_full || tx_busy));
      if (load) begin
        tx_sh <= tx_frame; tx_left <= tx_len; tx_sub <= '0;
        tx_busy <= 1'b1; tx_buf_full <= 1'b0;
      end else if (tx_busy && tick) begin
        if (tx_sub == S_TOP) begin
          tx_sub  <= '0;
          tx_sh   <= {1'b1, tx_sh[12:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end else
          tx_sub <= tx_sub + 1'b1;
      end
      if (wr_data) begin
        tx_buf <= {tx_b8, bus_wdata};
        tx_buf_full <= 1'b1;
      end
    end

  assign txd      = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_drive = tx_act;

  // receiver
  logic [1:0] rx_sy;
  logic rx_s, rx_busy, rx_pbit, maj, rx_done, pop, rx_pe_now;
  logic [CW-1:0] rx_sub;
  logic [3:0] rx_bit, rx_stop_idx;
  logic [1:0] rx_vote;
  logic [8:0] rx_dat, rx_hold;
  logic rx_full, rx_pe, rx_fe;

  assign rx_s        = rx_sy[1];
  assign maj         = ({1'b0, rx_vote} + {2'b00, rx_s}) >= 3'd2;
  assign rx_stop_idx = 4'd1 + nbits + {3'd0, par_on};
  assign rx_done     = rx_busy && tick && rx_sub == S_END && rx_bit == rx_stop_idx;
  assign rx_pe_now   = par_on && (rx_pbit != (^rx_dat ^ par_odd));
  assign pop         = bus_rd && bus_addr == 3'd0 && rx_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sy <= 2'b11; rx_busy <= 1'b0; rx_sub <= '0; rx_bit <= '0;
      rx_vote <= '0; rx_dat <= '0; rx_pbit <= 1'b0;
    end else begin
      rx_sy <= {rx_sy[0], rxd};
      if (!rx_busy) begin
        if (tick && rx_en && !rx_s) begin
          rx_busy <= 1'b1; rx_sub <= CW'(1); rx_bit <= '0;
          rx_vote <= '0; rx_dat <= '0;
        end
      end else if (tick) begin
        rx_sub <= rx_sub + 1'b1;
        if (rx_sub == S_LO || rx_sub == S_MID)
          rx_vote <= rx_vote + {1'b0, rx_s};
        if (rx_sub == S_END) begin
          rx_vote <= '0;
          if (rx_bit == 4'd0) begin
            if (maj) rx_busy <= 1'b0;
          end else if (rx_bit <= nbits)
            rx_dat[rx_bit - 4'd1] <= maj;
          else if (rx_bit == rx_stop_idx)
            rx_busy <= 1'b0;
          else
            rx_pbit <= maj;
        end
        if (rx_sub == S_TOP) rx_bit <= rx_bit + 4'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_hold <= '0; rx_full <= 1'b0; rx_pe <= 1'b0; rx_fe <= 1'b0;
    end else if (rx_done) begin
      rx_hold <= rx_dat; rx_full <= 1'b1; rx_pe <= rx_pe_now; rx_fe <= !maj;
    end else if (pop) begin
      rx_hold <= '0; rx_full <= 1'b0; rx_pe <= 1'b0; rx_fe <= 1'b0;
    end

  always_comb
    case (bus_addr)
      3'd0: bus_rdata = rx_hold[7:0];
      3'd1: bus_rdata = {3'b000, rx_hold[8], tx_b8, size_hi, rx_en, tx_en};
      3'd2: bus_rdata = {3'b000, stop2, par_mode, size_lo};
      3'd3: bus_rdata = {2'b00, tx_act, rx_fe, rx_pe, rx_full,
                         !tx_busy && !tx_buf_full, !tx_buf_full};
      3'd4: bus_rdata = 8'(div);
      default: bus_rdata = 8'h00;
    endcase
endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       txd,
  input logic       tx_drive,
  input logic       tx_busy,
  input logic       tx_buf_full,
  input logic       tx_en,
  input logic       rx_full,
  input logic       rx_done,
  input logic       rx_pe,
  input logic [1:0] par_mode
);
  // R8
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive |-> txd);
  // R8
  busy_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> tx_drive);
  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_drive) |-> (!$past(tx_busy) && !$past(tx_buf_full) && !$past(tx_en)));
  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> tx_buf_full);
  // R7
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && rx_full && !rx_done) |=> !rx_full);
  // R5
  perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pe |-> (rx_full && par_mode[1]));
endmodule

bind serial_xcvr serial_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .txd(txd), .tx_drive(tx_drive), .tx_busy(tx_busy), .tx_buf_full(tx_buf_full),
  .tx_en(tx_en), .rx_full(rx_full), .rx_done(rx_done), .rx_pe(rx_pe),
  .par_mode(par_mode)
);

// File: tb/serial_xcvr_tb_top.sv
module serial_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rxd, txd, tx_drive;
  logic use_ext = 1'b0, line = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign rxd = use_ext ? line : (tx_drive ? txd : 1'b1);

  serial_xcvr dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
    .txd(txd), .tx_drive(tx_drive));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_rx(output bit got);
    logic [7:0] s;
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      rd(3'd3, s);
      if (s[2]) got = 1;
    end
  endtask

  function automatic int nbits_of(input int code);
    case (code)
      0: return 5; 1: return 6; 2: return 7; 3: return 8; 7: return 9;
      default: return 8;
    endcase
  endfunction

  // expected line bits: start, data LSB first, parity, stops
  function automatic logic [12:0] frame_of(input int v, input int nb, input int p,
                                           input int st, output int len);
    logic [12:0] f;
    int par;
    f = '1; f[0] = 1'b0; par = 0;
    for (int i = 0; i < nb; i++) begin
      f[i+1] = v[i];
      par = par ^ v[i];
    end
    if (p >= 2) f[nb+1] = 1'(par ^ (p & 1));
    len = 2 + nb + (p >= 2 ? 1 : 0) + st;
    return f;
  endfunction

  task automatic send_ext(input logic [12:0] bits, input int n, input int gl);
    use_ext = 1'b1;
    for (int i = 0; i < n; i++)
      for (int c = 0; c < 16; c++) begin
        line = (i == gl && c == 8) ? ~bits[i] : bits[i];
        @(negedge clk);
      end
    line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    bit got;
    int codes[6] = '{0, 1, 2, 3, 7, 5};
    int v, nb, e, len;
    logic [12:0] f, cap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd2, s); check("R1 format reset", s, 8'h03);
    rd(3'd1, s); check("R1 control reset", s, 8'h00);
    rd(3'd3, s); check("R1 status reset", s, 8'h03);
    check("R1 txd idle", txd, 1);
    check("R1 tx_drive", tx_drive, 0);

    wr(3'd4, 8'd0);
    // loopback sweep: R2 R3 R4 R7
    for (int ci = 0; ci < 6; ci++)
      for (int p = 0; p < 4; p++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 4; k++) begin
            v = (k * 149 + 37 + ci * 11) & 9'h1FF;
            nb = nbits_of(codes[ci]);
            e = v & ((1 << nb) - 1);
            wr(3'd2, 8'({st[0], p[1:0], codes[ci][1:0]}));
            wr(3'd1, 8'({v[8], codes[ci][2], 2'b11}));
            wr(3'd0, 8'(v));
            wait_rx(got);
            check("R3 frame received", got, 1);
            rd(3'd1, s); check("R7 ninth bit held", s[4], e[8]);
            rd(3'd0, s); check("R2 data width", s, e & 8'hFF);
            rd(3'd3, s); check("R5 flags clear", s[4:3], 0);
            rd(3'd1, s); check("R7 ninth bit released", s[4], 0);
          end

    // line capture: R3 R4
    for (int ci = 0; ci < 6; ci++)
      for (int p = 0; p < 4; p++)
        for (int st = 0; st < 2; st++) begin
          v = (ci * 83 + p * 29 + st * 7 + 5) & 9'h1FF;
          nb = nbits_of(codes[ci]);
          f = frame_of(v, nb, p, st, len);
          wr(3'd2, 8'({st[0], p[1:0], codes[ci][1:0]}));
          wr(3'd1, 8'({v[8], codes[ci][2], 2'b11}));
          bus_addr = 3'd0; bus_wdata = 8'(v); bus_wr = 1'b1;
          @(negedge clk); bus_wr = 1'b0;
          cap = '1;
          for (int t = 0; t < 100 && txd; t++) @(negedge clk);
          repeat (8) @(negedge clk);
          for (int i = 0; i < len; i++) begin
            cap[i] = txd;
            if (i < len - 1) repeat (16) @(negedge clk);
          end
          check("R4 line frame", int'(cap & ((13'd1 << len) - 1)),
                int'(f & ((13'd1 << len) - 1)));
          wait_rx(got);
          rd(3'd0, s);
        end

    // R10 baud divisor
    wr(3'd2, 8'h03); wr(3'd1, 8'h03); wr(3'd4, 8'd2);
    wr(3'd0, 8'h01);
    for (int t = 0; t < 200 && txd; t++) @(negedge clk);
    e = 0;
    while (!txd && e < 1000) begin @(negedge clk); e++; end
    check("R10 start bit length", e, 48);
    wait_rx(got);
    rd(3'd0, s); check("R10 data at slow rate", s, 8'h01);
    wr(3'd4, 8'd0);

    // R5 parity and framing errors from external frames, R9 majority
    wr(3'd1, 8'h02);
    wr(3'd2, 8'h0B); // 8 bits even
    send_ext(13'b1_0_00000011_0, 11, -1);
    wait_rx(got); rd(3'd3, s); check("R5 good even parity", s[4:3], 0);
    rd(3'd0, s); check("R5 data", s, 8'h03);
    send_ext(13'b1_1_00000011_0, 11, -1);
    wait_rx(got); rd(3'd3, s); check("R5 parity error", s[4:3], 2'b01);
    rd(3'd0, s);
    rd(3'd3, s); check("R7 flags cleared by pop", s[4:2], 0);
    wr(3'd2, 8'h0F); // odd
    send_ext(13'b1_0_00000111_0, 11, -1);
    wait_rx(got); rd(3'd3, s); check("R5 good odd parity", s[4:3], 0);
    rd(3'd0, s);
    wr(3'd2, 8'h03);
    send_ext(13'b0_10100101_0, 10, -1);
    wait_rx(got); rd(3'd3, s); check("R5 framing error", s[4:3], 2'b10);
    rd(3'd0, s); check("R5 data with bad stop", s, 8'hA5);
    send_ext(13'b1_10100101_0, 10, 3);
    wait_rx(got); rd(3'd0, s); check("R9 centre disturbance ignored", s, 8'hA5);
    send_ext(13'b1_00111100_0, 10, 9);
    wait_rx(got); rd(3'd3, s); check("R9 stop disturbance ignored", s[4], 0);
    rd(3'd0, s); check("R9 data", s, 8'h3C);
    use_ext = 1'b1; line = 1'b0; repeat (4) @(negedge clk); line = 1'b1;
    repeat (300) @(negedge clk);
    rd(3'd3, s); check("R9 short start rejected", s[2], 0);
    send_ext(13'b1_01011010_0, 10, -1);
    wait_rx(got); rd(3'd0, s); check("R9 resync after false start", s, 8'h5A);
    use_ext = 1'b0;

    // R8 drain on disable
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h81); wr(3'd0, 8'h42);
    wr(3'd1, 8'h02);
    check("R8 still driving after disable", tx_drive, 1);
    wait_rx(got); rd(3'd0, s); check("R8 first drained", s, 8'h81);
    wait_rx(got); rd(3'd0, s); check("R8 second drained", s, 8'h42);
    repeat (20) @(negedge clk);
    check("R8 released", tx_drive, 0);
    check("R8 line high", txd, 1);
    wr(3'd0, 8'h99);
    repeat (300) @(negedge clk);
    rd(3'd3, s); check("R8 held while disabled", s[2:0], 3'b000);
    wr(3'd1, 8'h03);
    wait_rx(got); rd(3'd0, s); check("R8 held data sent", s, 8'h99);

    // R6 ninth-bit staging
    wr(3'd2, 8'h03);
    wr(3'd1, 8'h0F); wr(3'd0, 8'h11);
    wr(3'd1, 8'h07); wr(3'd0, 8'h22);
    wr(3'd1, 8'h0F);
    wait_rx(got); rd(3'd1, s); check("R6 first ninth bit", s[4], 1);
    rd(3'd0, s); check("R6 first low byte", s, 8'h11);
    wait_rx(got); rd(3'd1, s); check("R6 committed ninth bit kept", s[4], 0);
    rd(3'd0, s); check("R6 second low byte", s, 8'h22);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule